// File: doc/BRIEF.md
# Up-Counter Timer with One Compare Channel

This block is a register-mapped timer. A single up-counter advances on an external counter-clock enable, divided by a power-of-two prescaler. It wraps to zero after reaching a programmable modulo value and flags each wrap. One compare channel watches the counter. When it is armed in software-compare mode, it raises a sticky flag on the cycle the counter steps onto the compare value. It can also drive an interrupt line.

Software uses a simple word bus with a write strobe, a byte address and 32-bit data. Reads are combinational and have no side effects. The counter runs under a two-state controller. State RS_HALT leaves the counter frozen. State RS_RUN lets prescaled ticks advance it. A write to the status-and-control register with bit 3 set takes RS_HALT to RS_RUN. A write with bit 3 clear takes RS_RUN to RS_HALT. In every other cycle the state holds.

Register byte offsets: 0x04 width report, 0x10 status-and-control, 0x14 counter, 0x18 modulo, 0x1C global status, 0x20 channel control, 0x24 channel value.

Top module: `tmr_top`

## Requirements
- R1: After reset, every register reads zero, except the modulo register, which reads all ones, and the width register. The interrupt output is low.
- R2: The width register at 0x04 returns the counter width in bits 23:16 (0x20 for a 32-bit build) and zero in all other bits.
- R3: With status-and-control bit 3 clear, the counter holds its value. With it set, the counter advances only in cycles where the prescaler output fires, and only when `cnt_tick` is high.
- R4: Bits 2:0 of status-and-control select a division by 2^n. Each write to that register restarts the prescaler, so the next increment comes after exactly 2^n further enabled ticks. A tick in the same cycle as the write still uses the old settings.
- R5: On an advance from a count equal to the modulo value, the counter goes to zero and the overflow flag (status-and-control bit 7) is set. The flag then stays set.
- R6: Writing 1 to status-and-control bit 7 clears the overflow flag, and writing 0 there leaves it alone. If a wrap happens in the same cycle as the clearing write, the flag is set.
- R7: Any write to the counter register sets it to zero, whatever the data. The counter register reads the live count.
- R8: The channel control register holds the mode in bits 5:2, the interrupt enable in bit 6 and the flag in bit 7. With mode 0x4, the flag is set on an advance whose new count equals the channel value register. No other mode and no counter write ever sets it. A set in the same cycle as a clear wins.
- R9: Bit 0 of the global status register mirrors the channel flag. Writing 1 to that bit, or to bit 7 of channel control, clears the flag.
- R10: `irq` is high exactly while the channel flag and the channel interrupt enable are both set.
- R11: Reserved bits read zero. Unmapped or misaligned addresses read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Counter-clock enable, one tick per high cycle |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Channel interrupt |

## Verification
A wrong run state or a stale prescaler phase shows up in the counter readback. It appears on the first enabled tick after the fault, as a count one step early or late, or as a count that moves while stopped. A wrong flag state reaches the ports at once, because both flag registers and `irq` read it combinationally. A lost set or clear in a collision cycle is therefore visible in the very next read. A wrong modulo comparison shows up as a missing overflow flag, or as a count that passes the modulo value, within one wrap period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam logic [7:0] OFF_PARAM = 8'h04;
    localparam logic [7:0] OFF_SC    = 8'h10;
    localparam logic [7:0] OFF_CNT   = 8'h14;
    localparam logic [7:0] OFF_MOD   = 8'h18;
    localparam logic [7:0] OFF_GSTS  = 8'h1C;
    localparam logic [7:0] OFF_CSC   = 8'h20;
    localparam logic [7:0] OFF_CVAL  = 8'h24;

    localparam logic [3:0] MODE_SWCMP = 4'h4;

    typedef enum logic {
        RS_HALT = 1'b0,
        RS_RUN  = 1'b1
    } run_state_t;

endpackage

// File: rtl/tmr_run_fsm.sv
module tmr_run_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sc_wr,
    input  logic sc_mode,
    output logic run_o
);

    run_state_t state_q;
    run_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_HALT: if (sc_wr && sc_mode)  state_d = RS_RUN;
            RS_RUN:  if (sc_wr && !sc_mode) state_d = RS_HALT;
            default: state_d = RS_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RS_RUN:  run_o = 1'b1;
            default: run_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             adv_o
);

    localparam int PC_W = (1 << SEL_W) - 1;

    logic [PC_W-1:0] pcnt_q;
    logic [PC_W-1:0] limit;

    always_comb begin
        limit = PC_W'((64'd1 << sel) - 64'd1);
        adv_o = run && tick && (pcnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pcnt_q <= '0;
        else if (restart)        pcnt_q <= '0;
        else if (adv_o)          pcnt_q <= '0;
        else if (run && tick)    pcnt_q <= pcnt_q + 1'b1;
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         clr,
    input  logic [W-1:0] modv,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] nxt_o,
    output logic         step_o,
    output logic         wrap_o
);

    logic [W-1:0] cnt_q;

    always_comb begin
        step_o = adv && !clr;
        wrap_o = step_o && (cnt_q == modv);
        nxt_o  = (cnt_q == modv) ? '0 : cnt_q + 1'b1;
        cnt_o  = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (step_o) cnt_q <= nxt_o;
    end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] nxt,
    input  logic         ctl_wr,
    input  logic [3:0]   ctl_mode,
    input  logic         ctl_ie,
    input  logic         clr_req,
    input  logic         val_wr,
    input  logic [W-1:0] val_wdata,
    output logic [3:0]   mode_o,
    output logic         ie_o,
    output logic         flag_o,
    output logic [W-1:0] val_o
);

    logic [3:0]   mode_q;
    logic         ie_q;
    logic         flag_q;
    logic [W-1:0] val_q;
    logic         hit;

    assign hit = step && (mode_q == MODE_SWCMP) && (nxt == val_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            ie_q   <= 1'b0;
            val_q  <= '0;
        end else begin
            if (ctl_wr) begin
                mode_q <= ctl_mode;
                ie_q   <= ctl_ie;
            end
            if (val_wr) val_q <= val_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (hit)     flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end

    assign mode_o = mode_q;
    assign ie_o   = ie_q;
    assign flag_o = flag_q;
    assign val_o  = val_q;

endmodule

// File: rtl/tmr_top.sv
module tmr_top
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] A_PARAM = ADDR_W'(OFF_PARAM);
    localparam logic [ADDR_W-1:0] A_SC    = ADDR_W'(OFF_SC);
    localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(OFF_CNT);
    localparam logic [ADDR_W-1:0] A_MOD   = ADDR_W'(OFF_MOD);
    localparam logic [ADDR_W-1:0] A_GSTS  = ADDR_W'(OFF_GSTS);
    localparam logic [ADDR_W-1:0] A_CSC   = ADDR_W'(OFF_CSC);
    localparam logic [ADDR_W-1:0] A_CVAL  = ADDR_W'(OFF_CVAL);
    localparam logic [7:0]        WIDTH_CODE = 8'(CNT_W);

    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic wr_sc, wr_cnt, wr_mod, wr_gsts, wr_csc, wr_cval;

    logic [2:0]       psel_q;
    logic             tof_q;
    logic [CNT_W-1:0] mod_q;
    logic             run;
    logic             adv;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] cnt_nxt;
    logic             step;
    logic             wrap;
    logic [3:0]       ch_mode;
    logic             ch_ie;
    logic             ch_flag;
    logic [CNT_W-1:0] ch_val;
    logic             ch_clr;

    assign idx     = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    always_comb begin
        wr_sc   = bus_we && aligned && (idx == A_SC[ADDR_W-1:2]);
        wr_cnt  = bus_we && aligned && (idx == A_CNT[ADDR_W-1:2]);
        wr_mod  = bus_we && aligned && (idx == A_MOD[ADDR_W-1:2]);
        wr_gsts = bus_we && aligned && (idx == A_GSTS[ADDR_W-1:2]);
        wr_csc  = bus_we && aligned && (idx == A_CSC[ADDR_W-1:2]);
        wr_cval = bus_we && aligned && (idx == A_CVAL[ADDR_W-1:2]);
    end

    tmr_run_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sc_wr   (wr_sc),
        .sc_mode (bus_wdata[3]),
        .run_o   (run)
    );

    tmr_prescale #(.SEL_W(3)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (cnt_tick),
        .restart (wr_sc),
        .sel     (psel_q),
        .adv_o   (adv)
    );

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .clr    (wr_cnt),
        .modv   (mod_q),
        .cnt_o  (cnt_val),
        .nxt_o  (cnt_nxt),
        .step_o (step),
        .wrap_o (wrap)
    );

    assign ch_clr = (wr_csc && bus_wdata[7]) || (wr_gsts && bus_wdata[0]);

    tmr_chan #(.W(CNT_W)) u_ch0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .nxt       (cnt_nxt),
        .ctl_wr    (wr_csc),
        .ctl_mode  (bus_wdata[5:2]),
        .ctl_ie    (bus_wdata[6]),
        .clr_req   (ch_clr),
        .val_wr    (wr_cval),
        .val_wdata (bus_wdata[CNT_W-1:0]),
        .mode_o    (ch_mode),
        .ie_o      (ch_ie),
        .flag_o    (ch_flag),
        .val_o     (ch_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psel_q <= '0;
            mod_q  <= '1;
        end else begin
            if (wr_sc)  psel_q <= bus_wdata[2:0];
            if (wr_mod) mod_q  <= bus_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       tof_q <= 1'b0;
        else if (wrap)                    tof_q <= 1'b1;
        else if (wr_sc && bus_wdata[7])   tof_q <= 1'b0;
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (bus_addr)
                A_PARAM: bus_rdata = {8'h00, WIDTH_CODE, 16'h0000};
                A_SC:    bus_rdata = {24'h0, tof_q, 3'b000, run, psel_q};
                A_CNT:   bus_rdata = 32'(cnt_val);
                A_MOD:   bus_rdata = 32'(mod_q);
                A_GSTS:  bus_rdata = {31'h0, ch_flag};
                A_CSC:   bus_rdata = {24'h0, ch_flag, ch_ie, ch_mode, 2'b00};
                A_CVAL:  bus_rdata = 32'(ch_val);
                default: bus_rdata = '0;
            endcase
        end
    end

    assign irq = ch_flag && ch_ie;

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             adv,
    input logic             wr_cnt,
    input logic             wr_sc,
    input logic             wr_csc,
    input logic             wr_gsts,
    input logic [31:0]      bus_wdata,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W-1:0] mod_q,
    input logic             tof_q,
    input logic             ch_flag,
    input logic             ch_ie,
    input logic             irq
);

    p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt) |=> $stable(cnt_val));

    p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_cnt && (cnt_val != mod_q)) |=> (cnt_val == CNT_W'($past(cnt_val) + 1'b1)));

    p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_cnt && (cnt_val == mod_q)) |=> ((cnt_val == '0) && tof_q));

    p_tof_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tof_q && !(wr_sc && bus_wdata[7])) |=> tof_q);

    p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_val == '0));

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_flag && !(wr_csc && bus_wdata[7]) && !(wr_gsts && bus_wdata[0])) |=> ch_flag);

    p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_flag && ch_ie) |-> irq);

endmodule

bind tmr_top tmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .adv       (adv),
    .wr_cnt    (wr_cnt),
    .wr_sc     (wr_sc),
    .wr_csc    (wr_csc),
    .wr_gsts   (wr_gsts),
    .bus_wdata (bus_wdata),
    .cnt_val   (cnt_val),
    .mod_q     (mod_q),
    .tof_q     (tof_q),
    .ch_flag   (ch_flag),
    .ch_ie     (ch_ie),
    .irq       (irq)
);

// File: tb/test_tmr_top.sv
module test_tmr_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_PARAM = 6'h04;
    localparam logic [ADDR_W-1:0] A_GAP   = 6'h08;
    localparam logic [ADDR_W-1:0] A_SC    = 6'h10;
    localparam logic [ADDR_W-1:0] A_CNT   = 6'h14;
    localparam logic [ADDR_W-1:0] A_MOD   = 6'h18;
    localparam logic [ADDR_W-1:0] A_GSTS  = 6'h1C;
    localparam logic [ADDR_W-1:0] A_CSC   = 6'h20;
    localparam logic [ADDR_W-1:0] A_CVAL  = 6'h24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cnt_tick = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit mon_go = 1'b0;

    logic [31:0] exp_val_q[$];
    bit          exp_irq_q[$];
    string       exp_tag_q[$];

    tmr_top #(.CNT_W(32), .ADDR_W(ADDR_W)) i_tmr_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_tick  (cnt_tick),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: pops the scoreboard at the falling edge
    always @(negedge clk) begin
        if (mon_go && exp_val_q.size() > 0) begin
            logic [31:0] e;
            logic [31:0] a;
            bit          k;
            string       t;
            e = exp_val_q.pop_front();
            k = exp_irq_q.pop_front();
            t = exp_tag_q.pop_front();
            a = k ? {31'h0, irq} : bus_rdata;
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", t, a, e);
            end
        end
    end

    task automatic push_and_wait(input logic [31:0] e, input bit k, input string t);
        exp_val_q.push_back(e);
        exp_irq_q.push_back(k);
        exp_tag_q.push_back(t);
        mon_go = 1'b1;
        @(negedge clk);
        #1;
        mon_go = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string t);
        bus_addr = a;
        push_and_wait(e, 1'b0, t);
    endtask

    task automatic chk_irq(input bit e, input string t);
        push_and_wait({31'h0, e}, 1'b1, t);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic wr_tick(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; cnt_tick = 1'b1;
        @(posedge clk);
        #1;
        bus_we = 1'b0; cnt_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        cnt_tick = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        cnt_tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R1 / R2 reset state
        rd(A_PARAM, 32'h0020_0000, "R2 width code");
        rd(A_SC,    32'h0, "R1 sc reset");
        rd(A_CNT,   32'h0, "R1 cnt reset");
        rd(A_MOD,   32'hFFFF_FFFF, "R1 mod reset");
        rd(A_CSC,   32'h0, "R1 csc reset");
        rd(A_GSTS,  32'h0, "R1 gsts reset");
        rd(A_CVAL,  32'h0, "R1 cval reset");
        chk_irq(1'b0, "R1 irq reset");
        rd(A_GAP,   32'h0, "R11 unmapped read");

        // R3 stopped, then running
        ticks(5);
        rd(A_CNT, 32'h0, "R3 halted no count");
        wr(A_SC, 32'h08);
        ticks(5);
        rd(A_CNT, 32'h5, "R3 counts ticks");
        rd(A_CNT, 32'h5, "R3 no tick no count");

        // R7 counter write clears
        wr(A_CNT, 32'hDEAD);
        rd(A_CNT, 32'h0, "R7 write clears");

        // R4 prescaler divide by 4 and restart
        wr(A_SC, 32'h0A);
        ticks(3);
        rd(A_CNT, 32'h0, "R4 before 4th tick");
        ticks(1);
        rd(A_CNT, 32'h1, "R4 on 4th tick");
        ticks(8);
        rd(A_CNT, 32'h3, "R4 two more periods");
        ticks(2);
        wr(A_SC, 32'h0A);
        ticks(3);
        rd(A_CNT, 32'h3, "R4 restart discards phase");
        ticks(1);
        rd(A_CNT, 32'h4, "R4 full period after restart");

        // R5 / R6 wrap and overflow flag
        wr(A_SC, 32'h08);
        wr(A_CNT, 32'h0);
        wr(A_MOD, 32'h3);
        ticks(3);
        rd(A_CNT, 32'h3, "R5 reaches modulo");
        rd(A_SC,  32'h08, "R5 no flag yet");
        ticks(1);
        rd(A_CNT, 32'h0, "R5 wraps to zero");
        rd(A_SC,  32'h88, "R5 flag set");
        ticks(2);
        rd(A_SC,  32'h88, "R5 flag sticky");
        wr(A_SC, 32'h08);
        rd(A_SC,  32'h88, "R6 write 0 keeps flag");
        wr(A_SC, 32'h88);
        rd(A_SC,  32'h08, "R6 write 1 clears");
        ticks(1);
        wr_tick(A_SC, 32'h88);
        rd(A_CNT, 32'h0, "R6 wrap during clear");
        rd(A_SC,  32'h88, "R6 set wins");
        wr(A_SC, 32'h88);

        // R8 / R9 / R10 compare channel
        wr(A_MOD, 32'hFFFF_FFFF);
        wr(A_CNT, 32'h0);
        wr(A_CSC, 32'h10);
        wr(A_CVAL, 32'h5);
        ticks(4);
        rd(A_CSC,  32'h10, "R8 no match before");
        rd(A_GSTS, 32'h0, "R9 mirror clear");
        ticks(1);
        rd(A_CSC,  32'h90, "R8 match sets flag");
        rd(A_GSTS, 32'h1, "R9 mirror set");
        chk_irq(1'b0, "R10 disabled");
        wr(A_CSC, 32'h50);
        rd(A_CSC, 32'hD0, "R8 flag kept on ctl write");
        chk_irq(1'b1, "R10 enabled");
        ticks(3);
        rd(A_CSC, 32'hD0, "R9 flag sticky");
        wr(A_GSTS, 32'h1);
        rd(A_CSC,  32'h50, "R9 gsts clear");
        rd(A_GSTS, 32'h0, "R9 gsts reads 0");
        chk_irq(1'b0, "R10 low after clear");
        wr(A_CSC, 32'h48);
        wr(A_CNT, 32'h0);
        ticks(5);
        rd(A_CSC, 32'h48, "R8 other mode no match");
        chk_irq(1'b0, "R10 other mode");
        wr(A_CSC, 32'h50);
        wr(A_CVAL, 32'h0);
        wr(A_CNT, 32'h0);
        rd(A_CSC, 32'h50, "R8 counter write no match");
        wr(A_CVAL, 32'h3);
        wr(A_CNT, 32'h0);
        ticks(3);
        rd(A_CSC, 32'hD0, "R8 rematch");
        wr(A_CSC, 32'hD0);
        rd(A_CSC, 32'h50, "R9 ctl bit7 clears");
        wr(A_CNT, 32'h0);
        ticks(2);
        wr_tick(A_CSC, 32'hD0);
        rd(A_CSC, 32'hD0, "R8 set wins over clear");
        chk_irq(1'b1, "R10 after set wins");

        // R11 reserved bits and misaligned access
        wr(A_SC, 32'hFFFF_FFFF);
        rd(A_SC, 32'h0F, "R11 sc reserved zero");
        wr(A_CSC, 32'hFFFF_FFFF);
        rd(A_CSC, 32'h7C, "R11 csc reserved zero");
        wr(6'h19, 32'h1234);
        rd(A_MOD, 32'hFFFF_FFFF, "R11 misaligned write ignored");
        rd(6'h19, 32'h0, "R11 misaligned read zero");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule